// File: doc/BRIEF.md
# Three-Level Line Symbol Sampler

This block sits behind the two comparators of a differential two-wire serial receiver. One comparator reports that the line is at the positive level, which is ONE. The other reports the negative level, which is ZERO. When neither is active the line is at NULL. On every sample strobe the block classifies the line and shifts the result into one ten-sample history per level. From those histories it reports qualified symbols: a data bit of value one or zero, or a word-gap null.

The strobe is made from a 1 MHz tick input. In fast mode every tick is a sample. In slow mode only every eighth tick is a sample. A data bit is accepted only when two things hold: the pulse lasted at least three samples, and the line then returned to NULL within the window. A small state machine stops one long pulse from being reported twice. Word assembly and bit-rate checking are done by a later stage.

The controller has three states:
- `ST_ARMED`: ready for either data level.
- `ST_LOCK_ONE`: a ONE bit has just been reported.
- `ST_LOCK_ZERO`: a ZERO bit has just been reported.

Its transitions are taken only on sample strobes:
- `ARMED->LOCK_ONE` when a ONE qualifies.
- `ARMED->LOCK_ZERO` when a ZERO qualifies.
- `LOCK_ONE->LOCK_ZERO` when a ZERO qualifies.
- `LOCK_ZERO->LOCK_ONE` when a ONE qualifies.
- `LOCK_ONE->ARMED` when the ONE pattern no longer qualifies.
- `LOCK_ZERO->ARMED` when the ZERO pattern no longer qualifies.

A clear, caused by reset or a mode change, forces `ST_ARMED`.

Top module: `line_sampler`

## Requirements
- R1: Synchronous reset empties all three sample histories, the slow-mode tick count and the controller state. On the cycle after reset, `bit_valid` and `null_valid` are low.
- R2: With `low_speed`=0, every cycle with `time_tick` high is a sample. With `low_speed`=1, a sample is taken on the 8th, 16th, … tick counted since the last clear.
- R3: Each sample is classified as follows. `cmp_one` alone is ONE. `cmp_zero` alone is ZERO. Neither is NULL. Both together is no level at all, so it breaks every run.
- R4: A ONE bit qualifies on a strobe in two conditions. The five older samples of the ten-sample window (samples 5..9 strobes ago, with 0 the newest) must hold three consecutive ONE samples. The five newer samples must hold at least one NULL. The block then outputs `bit_valid`=1 with `bit_value`=1 for exactly one cycle, on the clock after that strobe.
- R5: A ZERO bit qualifies under the same rule with ZERO in place of ONE. It is reported with `bit_value`=0.
- R6: A pulse of fewer than three samples is never reported. A pulse that goes straight to the opposite level, with no NULL within the window, is not reported as its own level.
- R7: On every strobe where both halves of the window each hold three consecutive NULL samples, `null_valid` pulses for one cycle on the next clock.
- R8: After a bit of one level is reported, no further bit of that level is reported until a strobe at which that level's pattern no longer qualifies.
- R9: A change of `low_speed` clears the histories, the tick count and the state, as reset does. No output pulses on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| time_tick | input | 1 | One-cycle pulse from the 1 MHz time base |
| low_speed | input | 1 | 1 selects one sample per eight ticks |
| cmp_one | input | 1 | Comparator: line at the positive level |
| cmp_zero | input | 1 | Comparator: line at the negative level |
| bit_valid | output | 1 | One-cycle pulse: a data bit qualified |
| bit_value | output | 1 | Value of the qualified bit (valid with `bit_valid`) |
| null_valid | output | 1 | One-cycle pulse: a word-gap null qualified |

## Verification
The assertions take for granted that `rst` is synchronous, and that `low_speed` is a quasi-static level whose change is itself the clear. They also assume that an output pulse can only follow a cycle in which the internal strobe fired. The stimulus keeps within these bounds in several ways:
- `time_tick` is driven as a single-cycle pulse followed by an idle cycle.
- The comparator inputs change only between strobes.
- The mode changes only on cycles without a tick.

Within those bounds, a behavioural model built on a history queue predicts the outputs for every cycle.

// File: rtl/lsamp_pkg.sv
package lsamp_pkg;
    localparam int LV_ONE   = 0;
    localparam int LV_ZERO  = 1;
    localparam int LV_NULL  = 2;
    localparam int LV_COUNT = 3;

    typedef enum logic [1:0] {
        ST_ARMED     = 2'd0,
        ST_LOCK_ONE  = 2'd1,
        ST_LOCK_ZERO = 2'd2
    } lsamp_state_e;
endpackage

// File: rtl/lsamp_strobe.sv
module lsamp_strobe #(
    parameter int DIV_W = 3
) (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    input  logic slow,
    output logic strobe
);
    localparam logic [DIV_W-1:0] LAST = '1;

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (tick && slow) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign strobe = tick && !clr && (!slow || (cnt_q == LAST));
endmodule

// File: rtl/lsamp_shreg.sv
module lsamp_shreg #(
    parameter int WIN = 10
) (
    input  logic           clk,
    input  logic           clr,
    input  logic           shift,
    input  logic           din,
    output logic [WIN-1:0] nxt
);
    logic [WIN-1:0] win_q;

    assign nxt = {win_q[WIN-2:0], din};

    always_ff @(posedge clk) begin
        if (clr) begin
            win_q <= '0;
        end else if (shift) begin
            win_q <= nxt;
        end
    end
endmodule

// File: rtl/lsamp_qual.sv
module lsamp_qual #(
    parameter int WIN = 10,
    parameter int RUN = 3
) (
    input  logic [WIN-1:0] one_w,
    input  logic [WIN-1:0] zero_w,
    input  logic [WIN-1:0] null_w,
    output logic           one_ok,
    output logic           zero_ok,
    output logic           gap_ok
);
    localparam int HALF = WIN / 2;

    function automatic logic has_run(input logic [WIN-1:0] v, input int lo, input int hi);
        logic found;
        found = 1'b0;
        for (int k = lo; k <= hi - RUN + 1; k++) begin
            logic all_set;
            all_set = 1'b1;
            for (int j = 0; j < RUN; j++) begin
                all_set = all_set & v[k + j];
            end
            found = found | all_set;
        end
        return found;
    endfunction

    logic null_low;

    assign null_low = |null_w[HALF-1:0];
    assign one_ok   = has_run(one_w, HALF, WIN - 1) && null_low;
    assign zero_ok  = has_run(zero_w, HALF, WIN - 1) && null_low;
    assign gap_ok   = has_run(null_w, HALF, WIN - 1) && has_run(null_w, 0, HALF - 1);
endmodule

// File: rtl/line_sampler.sv
module line_sampler
    import lsamp_pkg::*;
#(
    parameter int WIN   = 10,
    parameter int RUN   = 3,
    parameter int DIV_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic time_tick,
    input  logic low_speed,
    input  logic cmp_one,
    input  logic cmp_zero,
    output logic bit_valid,
    output logic bit_value,
    output logic null_valid
);
    logic                mode_q;
    logic                clr;
    logic                strobe;
    logic [LV_COUNT-1:0] samp;
    logic [WIN-1:0]      win_n [LV_COUNT];
    logic                one_ok, zero_ok, gap_ok;
    lsamp_state_e        state_q, state_d;
    logic                emit_bit, emit_val;

    always_ff @(posedge clk) begin
        mode_q <= low_speed;
    end

    assign clr = rst || (low_speed != mode_q);

    lsamp_strobe #(.DIV_W(DIV_W)) u_strobe (
        .clk    (clk),
        .clr    (clr),
        .tick   (time_tick),
        .slow   (low_speed),
        .strobe (strobe)
    );

    always_comb begin
        samp          = '0;
        samp[LV_ONE]  = cmp_one & ~cmp_zero;
        samp[LV_ZERO] = cmp_zero & ~cmp_one;
        samp[LV_NULL] = ~cmp_one & ~cmp_zero;
    end

    for (genvar g = 0; g < LV_COUNT; g++) begin : g_level
        lsamp_shreg #(.WIN(WIN)) u_sr (
            .clk   (clk),
            .clr   (clr),
            .shift (strobe),
            .din   (samp[g]),
            .nxt   (win_n[g])
        );
    end

    lsamp_qual #(.WIN(WIN), .RUN(RUN)) u_qual (
        .one_w   (win_n[LV_ONE]),
        .zero_w  (win_n[LV_ZERO]),
        .null_w  (win_n[LV_NULL]),
        .one_ok  (one_ok),
        .zero_ok (zero_ok),
        .gap_ok  (gap_ok)
    );

    // next-state and emit decision
    always_comb begin
        state_d  = state_q;
        emit_bit = 1'b0;
        emit_val = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (one_ok) begin
                    state_d  = ST_LOCK_ONE;
                    emit_bit = 1'b1;
                    emit_val = 1'b1;
                end else if (zero_ok) begin
                    state_d  = ST_LOCK_ZERO;
                    emit_bit = 1'b1;
                end
            end
            ST_LOCK_ONE: begin
                if (zero_ok) begin
                    state_d  = ST_LOCK_ZERO;
                    emit_bit = 1'b1;
                end else if (!one_ok) begin
                    state_d = ST_ARMED;
                end
            end
            ST_LOCK_ZERO: begin
                if (one_ok) begin
                    state_d  = ST_LOCK_ONE;
                    emit_bit = 1'b1;
                    emit_val = 1'b1;
                end else if (!zero_ok) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ST_ARMED;
        end else if (strobe) begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (clr) begin
            bit_valid  <= 1'b0;
            bit_value  <= 1'b0;
            null_valid <= 1'b0;
        end else begin
            bit_valid  <= strobe && emit_bit;
            bit_value  <= strobe && emit_bit && emit_val;
            null_valid <= strobe && gap_ok;
        end
    end
endmodule

// File: rtl/line_sampler_chk.sv
module line_sampler_chk
    import lsamp_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         low_speed,
    input logic         strobe,
    input lsamp_state_e state_q,
    input logic         bit_valid,
    input logic         bit_value,
    input logic         null_valid
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!bit_valid && !null_valid));

    // R4
    bit_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(strobe));

    // R7
    null_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        null_valid |-> $past(strobe));

    // R7
    bit_null_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && null_valid));

    // R8
    one_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_value) |-> ($past(state_q) != ST_LOCK_ONE));

    // R8
    zero_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !bit_value) |-> ($past(state_q) != ST_LOCK_ZERO));

    // R9
    mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (low_speed != $past(low_speed)) |=> (!bit_valid && !null_valid));
endmodule

bind line_sampler line_sampler_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .low_speed  (low_speed),
    .strobe     (strobe),
    .state_q    (state_q),
    .bit_valid  (bit_valid),
    .bit_value  (bit_value),
    .null_valid (null_valid)
);

// File: tb/line_sampler_tb.sv
`timescale 1ns/1ps
module line_sampler_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic time_tick = 1'b0;
    logic low_speed = 1'b0;
    logic cmp_one = 1'b0;
    logic cmp_zero = 1'b0;
    logic bit_valid, bit_value, null_valid;

    always #2.5 clk = ~clk;

    line_sampler u_dut (
        .clk        (clk),
        .rst        (rst),
        .time_tick  (time_tick),
        .low_speed  (low_speed),
        .cmp_one    (cmp_one),
        .cmp_zero   (cmp_zero),
        .bit_valid  (bit_valid),
        .bit_value  (bit_value),
        .null_valid (null_valid)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int cnt_one = 0, cnt_zero = 0, cnt_null = 0;
    string cur_req = "R1";

    // behavioural reference: codes 0 none, 1 ONE, 2 ZERO, 3 NULL
    int hist[$];
    int pre = 0;
    int lock = 0;
    bit mode_m = 1'b0;
    bit exp_bv = 1'b0, exp_val = 1'b0, exp_nv = 1'b0;

    function automatic bit run3(int lvl, int lo, int hi);
        for (int k = lo; k <= hi - 2; k++)
            if (hist[k] == lvl && hist[k+1] == lvl && hist[k+2] == lvl) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit any_in(int lvl, int lo, int hi);
        for (int k = lo; k <= hi; k++)
            if (hist[k] == lvl) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_clear();
        hist.delete();
        for (int i = 0; i < 10; i++) hist.push_back(0);
        pre = 0;
        lock = 0;
    endtask

    always @(posedge clk) begin
        bit take;
        bit q1, q0, qg;
        int code;
        exp_bv = 1'b0; exp_val = 1'b0; exp_nv = 1'b0;
        if (rst || (low_speed != mode_m)) begin
            model_clear();
            mode_m = low_speed;
        end else if (time_tick) begin
            if (low_speed) begin
                take = (pre == 7);
                pre = (pre + 1) % 8;
            end else begin
                take = 1'b1;
            end
            if (take) begin
                if (cmp_one && cmp_zero) code = 0;
                else if (cmp_one) code = 1;
                else if (cmp_zero) code = 2;
                else code = 3;
                hist.push_front(code);
                void'(hist.pop_back());
                q1 = run3(1, 5, 9) && any_in(3, 0, 4);
                q0 = run3(2, 5, 9) && any_in(3, 0, 4);
                qg = run3(3, 5, 9) && run3(3, 0, 4);
                if (q1 && lock != 1) begin
                    exp_bv = 1'b1; exp_val = 1'b1; lock = 1;
                end else if (q0 && lock != 2) begin
                    exp_bv = 1'b1; lock = 2;
                end else if (lock == 1 && !q1) begin
                    lock = 0;
                end else if (lock == 2 && !q0) begin
                    lock = 0;
                end
                exp_nv = qg;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        cycles++;
        chk(bit_valid == exp_bv, cur_req, bit_valid, exp_bv);
        chk(null_valid == exp_nv, cur_req, null_valid, exp_nv);
        if (exp_bv) chk(bit_value == exp_val, cur_req, bit_value, exp_val);
        if (bit_valid && bit_value) cnt_one++;
        if (bit_valid && !bit_value) cnt_zero++;
        if (null_valid) cnt_null++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // one sample: code 1 ONE, 2 ZERO, 3 NULL, 4 both
    task automatic put(input int code);
        cmp_one  = (code == 1 || code == 4);
        cmp_zero = (code == 2 || code == 4);
        repeat (low_speed ? 8 : 1) begin
            time_tick = 1'b1;
            @(negedge clk);
            time_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int lvl, input int nhi, input int nnull);
        repeat (nhi) put(lvl);
        repeat (nnull) put(3);
    endtask

    task automatic clear_regs();
        low_speed = ~low_speed;
        @(negedge clk);
        low_speed = ~low_speed;
        @(negedge clk);
    endtask

    int b1, b0, bn;
    task automatic snap();
        b1 = cnt_one; b0 = cnt_zero; bn = cnt_null;
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!bit_valid && !null_valid, "R1", bit_valid + null_valid, 0);

        // R7: ten nulls from empty history give pulses on samples 8, 9 and 10
        cur_req = "R7";
        snap();
        pulse(3, 0, 10);
        chk(cnt_null - bn == 3, "R7", cnt_null - bn, 3);

        // R4: four well-formed ONE pulses
        cur_req = "R4";
        snap();
        repeat (4) pulse(1, 5, 5);
        chk(cnt_one - b1 == 4, "R4", cnt_one - b1, 4);
        chk(cnt_zero - b0 == 0, "R4", cnt_zero - b0, 0);

        // R5: four ZERO pulses
        cur_req = "R5";
        snap();
        repeat (4) pulse(2, 5, 5);
        chk(cnt_zero - b0 == 4, "R5", cnt_zero - b0, 4);
        chk(cnt_one - b1 == 0, "R5", cnt_one - b1, 0);

        // R6: two-sample pulses never qualify
        cur_req = "R6";
        clear_regs();
        snap();
        repeat (6) pulse(1, 2, 8);
        chk(cnt_one - b1 == 0, "R6", cnt_one - b1, 0);

        // R6: ONE going straight to ZERO is not a ONE bit
        clear_regs();
        snap();
        repeat (5) put(1);
        pulse(2, 8, 5);
        chk(cnt_one - b1 == 0, "R6", cnt_one - b1, 0);
        chk(cnt_zero - b0 == 1, "R6", cnt_zero - b0, 1);

        // R8: long pulses are reported once each
        cur_req = "R8";
        clear_regs();
        snap();
        repeat (3) pulse(1, 9, 10);
        chk(cnt_one - b1 == 3, "R8", cnt_one - b1, 3);

        // R3: both-active samples break null and data runs
        cur_req = "R3";
        clear_regs();
        snap();
        repeat (10) begin put(3); put(4); end
        chk(cnt_null - bn == 0, "R3", cnt_null - bn, 0);
        put(1); put(1); put(4); put(1); put(1);
        repeat (8) put(3);
        chk(cnt_one - b1 == 0, "R3", cnt_one - b1, 0);

        // R9: mode change erases a pulse in progress
        cur_req = "R9";
        clear_regs();
        snap();
        repeat (5) put(1);
        low_speed = 1'b1;
        @(negedge clk);
        chk(!bit_valid && !null_valid, "R9", bit_valid + null_valid, 0);
        repeat (5) put(3);
        chk(cnt_one - b1 == 0, "R9", cnt_one - b1, 0);

        // R2: slow mode samples once per eight ticks
        cur_req = "R2";
        clear_regs();
        snap();
        repeat (7) put(3);
        chk(cnt_null - bn == 0, "R2", cnt_null - bn, 0);
        repeat (3) put(3);
        chk(cnt_null - bn == 3, "R2", cnt_null - bn, 3);
        snap();
        repeat (2) pulse(1, 5, 5);
        chk(cnt_one - b1 == 2, "R2", cnt_one - b1, 2);

        // R1: reset in the middle of a pulse
        cur_req = "R1";
        low_speed = 1'b0;
        @(negedge clk);
        repeat (5) put(1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!bit_valid && !null_valid, "R1", bit_valid + null_valid, 0);
        snap();
        repeat (5) put(3);
        chk(cnt_one - b1 == 0, "R1", cnt_one - b1, 0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule